// File: doc/BRIEF.md
# Memory-Mapped I/O Bus Decoder

This block terminates a simple CPU-side bus with a 16-bit address, a 16-bit data path, an active-low select and one combined read/write line. Every access is routed by address range. The lower part of the space, 0x0000 to 0xEFFF, goes to an internal word-wide RAM. The top slice, 0xF000 to 0xFFFF, forms an I/O window. Inside that window, three word-aligned registers serve one simple input device: a control/status word and two data buffers. The device side loads both buffers with a one-cycle inject pulse, and this sets a ready flag. A CPU read of the first buffer clears that flag.

A read is accepted on the clock edge at which select is low and the read/write line is high. In the next cycle the result appears in a read-data buffer register, and a valid strobe is raised for that one cycle. The buffer keeps its value until the next read. A write is accepted on the clock edge at which select is low and the read/write line is low. It takes effect at that same edge. The RAM is a behavioural array with `2**RAM_AW` words, so the block can be tested by itself.

A response state machine records what was accepted at each edge. It has five states: `ST_IDLE`, `ST_WRITE`, `ST_RD_MEM`, `ST_RD_REG` and `ST_RD_HOLE`. The next state depends only on the request present at the edge, and it is the same from every state. The transitions are:
- `T_NONE` to `ST_IDLE` when select is high.
- `T_WRITE` to `ST_WRITE` on a write.
- `T_READ_MEM` to `ST_RD_MEM` on a read below 0xF000.
- `T_READ_REG` to `ST_RD_REG` on a read of a defined register.
- `T_READ_HOLE` to `ST_RD_HOLE` on a read of any other address in the I/O window.

The valid strobe is high in the three read states.

Top module: `mmio_bus_decoder`

## Requirements
- R1: Addresses below 0xF000 select the RAM. The word index is `bus_addr[RAM_AW:1]`. Bit 0 is ignored, and higher address bits alias onto the same words.
- R2: An access at 0xF000 or above never reads or writes the RAM, including the RAM word its low bits would alias to.
- R3: While `bus_sel_n` is high, no RAM word or register changes (whatever `bus_rw` is), and `bus_rvalid` stays low in the next cycle.
- R4: A read accepted at an edge raises `bus_rvalid` for exactly the following cycle, with the data in `bus_rdata`. `bus_rdata` keeps its value until the next read is accepted. Reads may follow each other back to back.
- R5: A write accepted at an edge stores `bus_wdata` at that edge, and a later read returns it.
- R6: The register addresses are status 0xFE70 (octal 177160), buffer A 0xFE72 (octal 177162) and buffer B 0xFE74 (octal 177164). Only these exact even addresses match, and both buffers can be written from the bus.
- R7: Every other address from 0xF000 up reads as 0x0000 and ignores writes.
- R8: The status word holds enable in bit 0 (read/write), ready in bit 8 (read-only) and overrun in bit 15 (read-only). All other bits read 0, and a bus write changes only bit 0.
- R9: An inject pulse loads buffer A from `dev_word_a` and buffer B from `dev_word_b`, and sets ready. If ready was already set, it also sets overrun.
- R10: A read of buffer A returns its value and clears both ready and overrun. If an inject happens in the same cycle, the inject wins and ready stays set.
- R11: If an inject and a bus write to a buffer happen in the same cycle, the injected word is kept.
- R12: After reset, `bus_rvalid` is 0, `bus_rdata` is 0x0000, and all three registers read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Active-low access select |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read-data buffer register |
| bus_rvalid | output | 1 | One-cycle pulse when read data is present |
| dev_inject | input | 1 | Device pulse: load buffers, set ready |
| dev_word_a | input | 16 | Word loaded into buffer A on inject |
| dev_word_b | input | 16 | Word loaded into buffer B on inject |

## Verification
Random traffic mixes several address patterns:
- RAM addresses anywhere below the window, with odd and even byte offsets, which shows whether aliasing and bit-0 handling are correct.
- The exact register addresses and their odd neighbours, which tells a real register match apart from a near miss.
- Random window addresses and the four range edges 0xEFFE, 0xEFFF, 0xF000 and 0xFFFF, which show where the RAM region ends and the hole begins.

Idle cycles with the write level on `bus_rw`, and injects at random times, show whether a deselected bus is truly ignored and whether ready and overrun are tracked correctly. Directed cases cover the same-cycle collisions: inject against a buffer-A read, and inject against a buffer write. They also write into the hole at an address that aliases a known RAM word.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] IO_BASE   = 16'hF000;
    localparam logic [ADDR_W-1:0] ADR_CSR   = 16'hFE70;
    localparam logic [ADDR_W-1:0] ADR_BUF_A = 16'hFE72;
    localparam logic [ADDR_W-1:0] ADR_BUF_B = 16'hFE74;

    localparam int CSR_EN_BIT  = 0;
    localparam int CSR_RDY_BIT = 8;
    localparam int CSR_OVR_BIT = 15;

    typedef enum logic [1:0] {
        RGN_MEM,
        RGN_REG,
        RGN_HOLE
    } region_t;

    typedef enum logic [1:0] {
        REG_CSR,
        REG_BUF_A,
        REG_BUF_B,
        REG_NONE
    } regsel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RD_MEM,
        ST_RD_REG,
        ST_RD_HOLE
    } state_t;
endpackage

// File: rtl/mmio_region_dec.sv
module mmio_region_dec
    import mmio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output regsel_t           regsel
);
    always_comb begin
        regsel = REG_NONE;
        if (addr < IO_BASE) begin
            region = RGN_MEM;
        end else begin
            unique case (addr)
                ADR_CSR:   regsel = REG_CSR;
                ADR_BUF_A: regsel = REG_BUF_A;
                ADR_BUF_B: regsel = REG_BUF_B;
                default:   regsel = REG_NONE;
            endcase
            region = (regsel == REG_NONE) ? RGN_HOLE : RGN_REG;
        end
    end
endmodule

// File: rtl/mmio_ram.sv
module mmio_ram
    import mmio_pkg::*;
#(
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << RAM_AW;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/mmio_dev_regs.sv
module mmio_dev_regs
    import mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  regsel_t           sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              inject,
    input  logic [DATA_W-1:0] word_a,
    input  logic [DATA_W-1:0] word_b,
    output logic [DATA_W-1:0] rdata
);
    logic              en_q;
    logic              rdy_q;
    logic              ovr_q;
    logic [DATA_W-1:0] buf_a_q;
    logic [DATA_W-1:0] buf_b_q;
    logic [DATA_W-1:0] csr_word;

    always_comb begin
        csr_word              = '0;
        csr_word[CSR_EN_BIT]  = en_q;
        csr_word[CSR_RDY_BIT] = rdy_q;
        csr_word[CSR_OVR_BIT] = ovr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            rdy_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (wr_en && sel == REG_CSR) begin
                en_q <= wdata[CSR_EN_BIT];
            end
            if (inject) begin
                rdy_q <= 1'b1;
                if (rdy_q) begin
                    ovr_q <= 1'b1;
                end
            end else if (rd_en && sel == REG_BUF_A) begin
                rdy_q <= 1'b0;
                ovr_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_a_q <= '0;
            buf_b_q <= '0;
        end else if (inject) begin
            buf_a_q <= word_a;
            buf_b_q <= word_b;
        end else if (wr_en) begin
            if (sel == REG_BUF_A) buf_a_q <= wdata;
            if (sel == REG_BUF_B) buf_b_q <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            REG_CSR:   rdata = csr_word;
            REG_BUF_A: rdata = buf_a_q;
            REG_BUF_B: rdata = buf_b_q;
            default:   rdata = '0;
        endcase
    end

    // R9: an inject always leaves ready set
    a_r9_inject_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        inject |=> rdy_q);
    // R10: a buffer-A read with no inject leaves ready and overrun clear
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == REG_BUF_A && !inject) |=> (!rdy_q && !ovr_q));
    // R11: the injected word wins over a same-cycle bus write
    a_r11_inject_wins: assert property (@(posedge clk) disable iff (!rst_n)
        inject |=> (buf_a_q == $past(word_a) && buf_b_q == $past(word_b)));
    // R8: overrun never stands without ready
    a_r8_ovr_implies_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> rdy_q);
endmodule

// File: rtl/mmio_bus_decoder.sv
module mmio_bus_decoder
    import mmio_pkg::*;
#(
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_rw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              dev_inject,
    input  logic [DATA_W-1:0] dev_word_a,
    input  logic [DATA_W-1:0] dev_word_b
);
    region_t           region;
    regsel_t           regsel;
    state_t            state_q;
    state_t            state_d;
    logic              rd_req;
    logic              wr_req;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] reg_rdata;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdbuf_q;

    mmio_region_dec u_dec (
        .addr   (bus_addr),
        .region (region),
        .regsel (regsel)
    );

    assign rd_req = !bus_sel_n && bus_rw;
    assign wr_req = !bus_sel_n && !bus_rw;
    assign ram_we = wr_req && (region == RGN_MEM);

    mmio_ram #(.RAM_AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (bus_addr[RAM_AW:1]),
        .wdata (bus_wdata),
        .rdata (ram_rdata)
    );

    mmio_dev_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_req && region == RGN_REG),
        .rd_en  (rd_req && region == RGN_REG),
        .sel    (regsel),
        .wdata  (bus_wdata),
        .inject (dev_inject),
        .word_a (dev_word_a),
        .word_b (dev_word_b),
        .rdata  (reg_rdata)
    );

    // next state: same from every state, named transitions T_*
    always_comb begin
        if (bus_sel_n) begin
            state_d = ST_IDLE;                       // T_NONE
        end else if (!bus_rw) begin
            state_d = ST_WRITE;                      // T_WRITE
        end else begin
            unique case (region)
                RGN_MEM: state_d = ST_RD_MEM;        // T_READ_MEM
                RGN_REG: state_d = ST_RD_REG;        // T_READ_REG
                default: state_d = ST_RD_HOLE;       // T_READ_HOLE
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (region)
            RGN_MEM: rd_mux = ram_rdata;
            RGN_REG: rd_mux = reg_rdata;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdbuf_q <= '0;
        else if (rd_req) rdbuf_q <= rd_mux;
    end

    // output process
    always_comb begin
        bus_rdata = rdbuf_q;
        unique case (state_q)
            ST_RD_MEM, ST_RD_REG, ST_RD_HOLE: bus_rvalid = 1'b1;
            default:                          bus_rvalid = 1'b0;
        endcase
    end

    // R3: deselected bus never writes RAM
    a_r3_idle_no_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel_n |-> !ram_we);
    // R2: window accesses never write RAM
    a_r2_window_no_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= IO_BASE) |-> !ram_we);
    // R4: an accepted read raises valid next cycle
    a_r4_read_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel_n && bus_rw) |=> bus_rvalid);
    // R3: with select high, no valid next cycle
    a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel_n |=> !bus_rvalid);
    // R4: read data holds while no read is presented
    a_r4_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> $stable(bus_rdata));
    // R7: a hole read returns zero
    a_r7_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_HOLE) |-> (bus_rdata == '0));
endmodule

// File: tb/mmio_bus_decoder_bench.sv
module mmio_bus_decoder_bench;
    localparam int RAM_AW = 8;
    localparam int WORDS  = 1 << RAM_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel_n = 1'b1;
    logic        bus_rw = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        dev_inject = 1'b0;
    logic [15:0] dev_word_a = '0;
    logic [15:0] dev_word_b = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] m_ram [WORDS];
    logic        m_en = 1'b0, m_rdy = 1'b0, m_ovr = 1'b0;
    logic [15:0] m_ba = '0, m_bb = '0;
    logic [15:0] last_rdata = '0;

    always #4 clk = ~clk;

    mmio_bus_decoder #(.RAM_AW(RAM_AW)) u_mmio_bus_decoder (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_rw(bus_rw),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .dev_inject(dev_inject),
        .dev_word_a(dev_word_a), .dev_word_b(dev_word_b)
    );

    function automatic logic [15:0] csr_val();
        logic [15:0] v = '0;
        v[0] = m_en; v[8] = m_rdy; v[15] = m_ovr;
        return v;
    endfunction

    function automatic logic [15:0] exp_read(input logic [15:0] a);
        if (a < 16'hF000) return m_ram[a[RAM_AW:1]];
        case (a)
            16'hFE70: return csr_val();
            16'hFE72: return m_ba;
            16'hFE74: return m_bb;
            default:  return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [15:0] a);
        if (a < 16'hF000) return "R1";
        if (a == 16'hFE70) return "R8";
        if (a == 16'hFE72 || a == 16'hFE74) return "R6";
        return "R7";
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus cycle; called at a negedge, returns at the next negedge
    task automatic op(input logic sel_n, input logic rw, input logic [15:0] a,
                      input logic [15:0] wd, input logic inj,
                      input logic [15:0] wa, input logic [15:0] wb, input string req);
        logic [15:0] e;
        logic        is_rd;
        logic        old_rdy;
        bus_sel_n = sel_n; bus_rw = rw; bus_addr = a; bus_wdata = wd;
        dev_inject = inj; dev_word_a = wa; dev_word_b = wb;
        is_rd = !sel_n && rw;
        e = exp_read(a);
        old_rdy = m_rdy;
        @(posedge clk);
        @(negedge clk);
        // model update (R5, R8, R9, R10, R11)
        if (!sel_n) begin
            if (rw) begin
                if (a == 16'hFE72) begin m_rdy = 1'b0; m_ovr = 1'b0; end
            end else begin
                if (a < 16'hF000) m_ram[a[RAM_AW:1]] = wd;
                else if (a == 16'hFE70) m_en = wd[0];
                else if (a == 16'hFE72) m_ba = wd;
                else if (a == 16'hFE74) m_bb = wd;
            end
        end
        if (inj) begin
            m_ba = wa; m_bb = wb; m_rdy = 1'b1;
            if (old_rdy) m_ovr = 1'b1;
        end
        if (is_rd) begin
            check({req, " rvalid"}, {15'd0, bus_rvalid}, 16'd1);
            check(req, bus_rdata, e);
            last_rdata = e;
        end else begin
            check("R4 no-read valid", {15'd0, bus_rvalid}, 16'd0);
            check("R4 rdata hold", bus_rdata, last_rdata);
        end
        bus_sel_n = 1'b1; dev_inject = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        op(1'b0, 1'b1, a, 16'h0, 1'b0, 16'h0, 16'h0, req);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        op(1'b0, 1'b0, a, d, 1'b0, 16'h0, 16'h0, "R5");
    endtask

    task automatic idle_inject(input logic [15:0] wa, input logic [15:0] wb);
        op(1'b1, 1'b0, 16'h0, 16'h0, 1'b1, wa, wb, "R9");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] a;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("R12 rvalid", {15'd0, bus_rvalid}, 16'd0);
        check("R12 rdata", bus_rdata, 16'h0000);
        rd(16'hFE70, "R12 csr");
        rd(16'hFE72, "R12 buf_a");
        rd(16'hFE74, "R12 buf_b");

        // fill RAM so every later read is defined (R5)
        for (int i = 0; i < WORDS; i++) wr(16'(i * 2), 16'($urandom));

        // R1 aliasing and bit 0 ignored
        wr(16'h0000, 16'h1234);
        rd(16'h0001, "R1 odd byte");
        rd(16'(WORDS * 2), "R1 alias");
        // R2 / R7: hole write aliasing word 0 must not touch RAM
        wr(16'hF000, 16'hBEEF);
        rd(16'h0000, "R2 ram untouched");
        rd(16'hF000, "R7 hole zero");
        rd(16'hFE71, "R6 odd neighbour");
        // R3: deselected write-level cycle changes nothing
        op(1'b1, 1'b0, 16'h0000, 16'hDEAD, 1'b0, 16'h0, 16'h0, "R3");
        rd(16'h0000, "R3 ram kept");
        // R8: only enable is writable
        wr(16'hFE70, 16'hFFFF);
        rd(16'hFE70, "R8 csr mask");
        // R9: inject, then overrun on second inject
        idle_inject(16'hA5A5, 16'h5A5A);
        rd(16'hFE70, "R9 ready");
        idle_inject(16'h1111, 16'h2222);
        rd(16'hFE70, "R9 overrun");
        rd(16'hFE74, "R9 buf_b");
        // R10: read of buffer A clears flags
        rd(16'hFE72, "R10 buf_a");
        rd(16'hFE70, "R10 cleared");
        // R10: inject during buffer-A read wins
        op(1'b0, 1'b1, 16'hFE72, 16'h0, 1'b1, 16'h3333, 16'h4444, "R10 collide");
        rd(16'hFE70, "R10 ready kept");
        // R11: inject vs write to buffer B
        op(1'b0, 1'b0, 16'hFE74, 16'h9999, 1'b1, 16'h5555, 16'h6666, "R11");
        rd(16'hFE74, "R11 buf_b");
        rd(16'hFE70, "R11 csr");
        // R4: back-to-back reads
        rd(16'hEFFE, "R4 b2b 1");
        rd(16'hEFFF, "R4 b2b 2");
        rd(16'hFFFF, "R4 b2b 3");

        // constrained random traffic
        for (int n = 0; n < 600; n++) begin
            int k;
            k = int'($urandom % 8);
            case (k)
                0, 1, 2, 3: a = 16'($urandom % 32'hF000);
                4, 5: a = 16'hFE70 + 16'(2 * ($urandom % 3)) + 16'($urandom % 4 == 0);
                6: a = 16'hF000 + 16'($urandom % 32'h1000);
                default: begin
                    case ($urandom % 4)
                        0: a = 16'hEFFE;
                        1: a = 16'hEFFF;
                        2: a = 16'hF000;
                        default: a = 16'hFFFF;
                    endcase
                end
            endcase
            op(($urandom % 8) == 0, $urandom % 2 == 0, a, 16'($urandom),
               ($urandom % 10) == 0, 16'($urandom), 16'($urandom), tag_of(a));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule